// File: doc/BRIEF.md
# Paged Open-Drain DIO Register Interface

This block is the host-facing register front end of a 48-line general-purpose I/O chip. The lines are grouped into six byte-wide ports. Every line is open-drain. A line that holds a 1 in its output latch sinks current and pulls the pad low. A line that holds a 0 releases the pad, so an external pull-up raises it and the line can serve as an input. Reads of a port return the pad level inverted. Each pad level first passes through a two-flop synchronizer.

A single control register at offset 7 does two jobs. Its top two bits pick one of four pages. Its low six bits are write locks, one per port. In pages 1 to 3, offsets 8 to 10 are not stored here. Those accesses go out on a small strobe interface to a neighbouring edge-interrupt block, which holds the polarity, enable and interrupt-ID bytes. The pending status from that block is visible at offset 6.

Each chip decodes one 16-byte window of a wider address. A second chip uses the next window, so two copies with different `CHIP_IDX` values can share one strobe bus, and their read data can be OR-ed together.

Top module: `dio_bank_if`

## Requirements
- R1: After reset every line is released (`pin_sink` all 0), the page field is 0 and all six lock bits are 0, so a read of offset 7 returns 0x00.
- R2: A write to offset p (0 to 5) loads port p's output latch, and `pin_sink[8p+7:8p]` shows it from the next cycle. A 1 drives the pad low and a 0 releases it.
- R3: A read of offset p (0 to 5) returns the bitwise inverse of port p's pad levels, on `bus_rdata` in the cycle after the read strobe. A pad change becomes visible to a read only after two synchronizer stages.
- R4: Offset 7 is the control register. Bits 7:6 select the page (0 to 3) and bit k (k = 0 to 5) is the lock for port k. It reads back exactly as written.
- R5: While port k's lock bit is 1, writes to offset k leave that port's latch unchanged. Reads of the port and writes to unlocked ports work as usual.
- R6: Offsets 0 to 5 reach the port registers in every page.
- R7: A read of offset 6 returns {5'b0, irq_pend[2:0]}.
- R8: In pages 1, 2 and 3, an access to offset 8, 9 or 10 raises `pg_wr` or `pg_rd` in the same cycle. It also presents `pg_page` equal to the page, `pg_idx` equal to offset minus 8, and `pg_wdata` equal to the written byte. A read returns `pg_rdata` on the next cycle.
- R9: In page 0, offsets 8 to 10 raise no paged strobe and read as 0x00. Offsets 11 to 15 read as 0x00 in any page, and writes to them change nothing.
- R10: Only addresses whose bits above bit 3 equal `CHIP_IDX` are decoded. Other addresses change no state and return 0x00.
- R11: `bus_rdata` is 0x00 in every cycle that does not follow a decoded read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address; bits 3:0 select the offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd`, otherwise 0 |
| pin_in | input | 48 | Pad levels, asynchronous |
| pin_sink | output | 48 | Per-line pull-down enable (1 = sink current) |
| irq_pend | input | 3 | Pending status from the edge-interrupt block |
| pg_wr | output | 1 | Paged register write strobe |
| pg_rd | output | 1 | Paged register read strobe |
| pg_page | output | 2 | Selected page |
| pg_idx | output | 2 | Byte index 0 to 2 within the paged bank |
| pg_wdata | output | 8 | Paged write data |
| pg_rdata | input | 8 | Paged read data, combinational from the neighbour |

## Verification
The embedded properties check four things on every cycle. A locked port's latch never moves. An access outside the window disturbs no latch. The read bus stays at zero outside read responses. A paged strobe only appears with a nonzero page and an index of 0 to 2. The scoreboard bench covers the behaviours that depend on data values and timing, which only its scenarios can show. These are the inverted read-back through the external pull-up model, the two-cycle synchronizer delay, and page-dependent forwarding with the neighbour's returned byte. It also covers the reset values and the zero result for unmapped and page-0 offsets.

// File: rtl/dio_bank_if.sv
module dio_bank_if #(
  parameter int ADDR_W   = 5,
  parameter int CHIP_IDX = 0,
  parameter int NPORT    = 6,
  parameter int PEND_W   = 3,
  localparam int NLINE   = NPORT * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NLINE-1:0]  pin_in,
  output logic [NLINE-1:0]  pin_sink,
  input  logic [PEND_W-1:0] irq_pend,
  output logic              pg_wr,
  output logic              pg_rd,
  output logic [1:0]        pg_page,
  output logic [1:0]        pg_idx,
  output logic [7:0]        pg_wdata,
  input  logic [7:0]        pg_rdata
);
  localparam int HI_W = ADDR_W - 4;
  localparam logic [3:0] OFF_PEND = 4'd6;
  localparam logic [3:0] OFF_CTRL = 4'd7;

  logic [3:0]       off;
  logic             hit, wr_hit, rd_hit, pg_win;
  logic [1:0]       page_q;
  logic [NPORT-1:0] lock_q;
  logic [NLINE-1:0] lat_q, sync1_q, sync2_q;
  logic [7:0]       rd_val;

  assign off    = bus_addr[3:0];
  assign hit    = bus_addr[ADDR_W-1:4] == HI_W'(CHIP_IDX);
  assign wr_hit = bus_wr && hit;
  assign rd_hit = bus_rd && hit;
  assign pg_win = (off >= 4'd8) && (off <= 4'd10) && (page_q != 2'd0);

  assign pg_wr    = wr_hit && pg_win;
  assign pg_rd    = rd_hit && pg_win;
  assign pg_page  = page_q;
  assign pg_idx   = off[1:0];
  assign pg_wdata = bus_wdata;
  assign pin_sink = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      page_q <= 2'd0;
      lock_q <= '0;
    end else if (wr_hit) begin
      for (int p = 0; p < NPORT; p++)
        if (off == 4'(p) && !lock_q[p])
          lat_q[p*8 +: 8] <= bus_wdata;
      if (off == OFF_CTRL) begin
        page_q <= bus_wdata[7:6];
        lock_q <= bus_wdata[NPORT-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int p = 0; p < NPORT; p++)
      if (off == 4'(p))
        rd_val = ~sync2_q[p*8 +: 8];
    if (off == OFF_PEND) rd_val = 8'(irq_pend);
    if (off == OFF_CTRL) rd_val = {page_q, lock_q};
    if (pg_win)          rd_val = pg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else        bus_rdata <= rd_hit ? rd_val : 8'h00;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_lock_chk
    p_locked_port_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[p] |=> $stable(lat_q[p*8 +: 8]));
  end

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> ($stable(lat_q) && $stable(page_q) && $stable(lock_q)));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (bus_rdata == 8'h00));

  p_pg_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr || pg_rd) |-> ((pg_page != 2'd0) && (pg_idx != 2'd3)));
endmodule

// File: tb/dio_bank_if_tb_top.sv
`timescale 1ns/1ps
module dio_bank_if_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] ext_high = '1;
  logic [47:0] pin_in, pin_sink;
  logic [2:0]  irq_pend = '0;
  logic        pg_wr, pg_rd;
  logic [1:0]  pg_page, pg_idx;
  logic [7:0]  pg_wdata, pg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  bit rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  assign pin_in   = ext_high & ~pin_sink;
  assign pg_rdata = {pg_page, 4'h5, pg_idx};

  dio_bank_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_sink(pin_sink), .irq_pend(irq_pend),
    .pg_wr(pg_wr), .pg_rd(pg_rd), .pg_page(pg_page), .pg_idx(pg_idx),
    .pg_wdata(pg_wdata), .pg_rdata(pg_rdata));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(64'(bus_rdata), 64'(e), t);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [4:0] a, input logic [7:0] d, input bit exp_pg, input string tag);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1;
    chk(64'(pg_wr), 64'(exp_pg), {tag, " pg_wr"});
    if (exp_pg) chk(64'(pg_wdata), 64'(d), {tag, " pg_wdata"});
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic brd(input logic [4:0] a, input logic [7:0] e, input bit exp_pg, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    #1;
    chk(64'(pg_rd), 64'(exp_pg), {tag, " pg_rd"});
    @(negedge clk);
    bus_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk(64'(pin_sink), 64'd0, "R1 pin_sink");
    brd(5'h07, 8'h00, 0, "R1 ctrl");
    idle(2);
    brd(5'h00, 8'h00, 0, "R1 port0 released");
    // R2
    bwr(5'h00, 8'hA5, 0, "R2");
    bwr(5'h05, 8'h3C, 0, "R2");
    chk(64'(pin_sink[7:0]), 64'hA5, "R2 port0");
    chk(64'(pin_sink[47:40]), 64'h3C, "R2 port5");
    // R3
    idle(3);
    brd(5'h00, 8'hA5, 0, "R3 port0 inverted");
    brd(5'h05, 8'h3C, 0, "R3 port5 inverted");
    ext_high[15:8] = 8'h0F;
    brd(5'h01, 8'h00, 0, "R3 sync still old");
    brd(5'h01, 8'hF0, 0, "R3 sync new");
    // R4, R6
    bwr(5'h07, 8'h80, 0, "R4");
    brd(5'h07, 8'h80, 0, "R4 readback");
    bwr(5'h01, 8'h11, 0, "R6");
    idle(3);
    chk(64'(pin_sink[15:8]), 64'h11, "R6 write in page2");
    brd(5'h01, 8'hF1, 0, "R6 read in page2");
    // R7
    irq_pend = 3'b101;
    brd(5'h06, 8'h05, 0, "R7");
    // R8
    bwr(5'h09, 8'h5A, 1, "R8 page2");
    @(negedge clk); bus_wr = 1; bus_addr = 5'h0A; bus_wdata = 8'h77; #1;
    chk(64'({pg_page, pg_idx}), 64'({2'd2, 2'd2}), "R8 page/idx");
    @(negedge clk); bus_wr = 0;
    brd(5'h0A, 8'h96, 1, "R8 read page2");
    bwr(5'h07, 8'hC0, 0, "R8");
    brd(5'h08, 8'hD4, 1, "R8 read page3");
    // R9
    bwr(5'h07, 8'h00, 0, "R9");
    bwr(5'h09, 8'hFF, 0, "R9 page0 write");
    brd(5'h09, 8'h00, 0, "R9 page0 read");
    bwr(5'h0D, 8'hFF, 0, "R9 unmapped write");
    brd(5'h0C, 8'h00, 0, "R9 unmapped read");
    brd(5'h07, 8'h00, 0, "R9 ctrl untouched");
    chk(64'(pin_sink), 64'h3C0000_0011A5, "R9 latches untouched");
    // R5
    bwr(5'h07, 8'h01, 0, "R5");
    bwr(5'h00, 8'h00, 0, "R5 locked");
    chk(64'(pin_sink[7:0]), 64'hA5, "R5 locked port held");
    bwr(5'h01, 8'h22, 0, "R5 unlocked");
    chk(64'(pin_sink[15:8]), 64'h22, "R5 unlocked port");
    idle(3);
    brd(5'h00, 8'hA5, 0, "R5 read locked port");
    // R10
    bwr(5'h10, 8'hFF, 0, "R10");
    bwr(5'h17, 8'hFF, 0, "R10");
    chk(64'(pin_sink[7:0]), 64'hA5, "R10 no write");
    brd(5'h17, 8'h00, 0, "R10 miss read");
    brd(5'h07, 8'h01, 0, "R10 ctrl untouched");
    // R11
    idle(2);
    chk(64'(bus_rdata), 64'h00, "R11 idle");
    idle(2);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d reads unanswered", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule